// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept or discarded, looking only at its destination address. The six address octets arrive one per clock on a byte input. A valid qualifier marks each octet, and a start strobe marks the first one. While the octets arrive, the block runs the Ethernet CRC-32 over them. The six most significant bits of the resulting CRC register form an index into a 64-bit hash table. Software holds that table as four 16-bit registers and reaches them through a small write/read port.

A controller state machine has three states:
- `ST_IDLE`: waiting for a first octet.
- `ST_COLLECT`: accumulating octets.
- `ST_DECIDE`: a one-cycle state that presents the decision.

It makes these transitions:
- `ST_IDLE` → `ST_COLLECT` on a start octet.
- `ST_COLLECT` → `ST_COLLECT` on every further octet until the sixth. A fresh start octet also keeps it in `ST_COLLECT` and restarts the address.
- `ST_COLLECT` → `ST_DECIDE` on the sixth octet.
- `ST_DECIDE` → `ST_COLLECT` when a start octet arrives in that cycle.
- `ST_DECIDE` → `ST_IDLE` otherwise.

Three mode inputs shape the decision:
- hash-filter enable, which selects the hash scheme;
- receive-all;
- receive-multicast.

Either of the last two lets every multicast destination through. Destinations that are not multicast never match.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all four table registers read as 0x0000 and `dec_valid` is low.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is stored into the register chosen by `reg_sel`. `reg_rdata` always shows the register currently chosen by `reg_sel`, combinationally.
- R3: The hash index is bits 31..26 of a CRC register that is computed as follows:
  - the register is preset to 0xFFFFFFFF;
  - each octet is processed least significant bit first;
  - for each bit, feedback = crc[31] XOR bit, then the register shifts left by one and is XORed with 0x04C11DB7 when the feedback is 1;
  - no final inversion is applied.
- R4: Index bits 5..4 choose the table register (0..3), and index bits 3..0 choose the bit within that register.
- R5: For a multicast destination with hash filtering enabled and no override, `dec_accept` is 1 when the indexed table bit is 1 and 0 when it is 0.
- R6: When `rx_all` or `rx_mcast` is high during the decision cycle, every multicast destination gets `dec_accept` = 1, whatever the table holds.
- R7: A destination whose first octet has bit 0 clear is not multicast. It gets `dec_accept` = 0 under every mode and table setting.
- R8: With `hash_en`, `rx_all` and `rx_mcast` all low, a multicast destination gets `dec_accept` = 0.
- R9: Octet timing and the decision pulse:
  - an octet is taken only in a cycle where `addr_valid` is high;
  - the first octet also carries `addr_start`;
  - idle cycles may fall between octets;
  - `dec_valid` is high for exactly the one cycle after the clock edge that samples the sixth octet, and is low at all other times.
- R10: A start octet that arrives before the sixth octet discards the partial address, and the new address is decided on its own.
- R11: A table write in the decision cycle does not change that decision. The written value is used for the next lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_start | input | 1 | Marks the first destination octet |
| addr_valid | input | 1 | Octet qualifier |
| addr_byte | input | 8 | Destination address octet |
| hash_en | input | 1 | Hash-table filtering enabled |
| rx_all | input | 1 | Receive-all override |
| rx_mcast | input | 1 | Receive-multicast override |
| reg_sel | input | 2 | Table register select |
| reg_wdata | input | 16 | Table write data |
| reg_we | input | 1 | Table write enable |
| reg_rdata | output | 16 | Selected table register |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = accept, 0 = drop |

## Verification
The bench builds the block with its default parameters:
- six address octets;
- four 16-bit table registers;
- a 32-bit CRC with the Ethernet polynomial.

With these values the whole 64-entry index space is reachable. A bench function computes the expected index, and directed cases set or clear exactly the addressed bit. With only six octets per address, random gaps, restarts after a partial address, and writes landing on the decision cycle can all be driven within a few cycles of each other.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int unsigned OCTET_W    = 8;
    localparam int unsigned CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } mhf_state_e;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step #(
    parameter int unsigned          CRC_W  = 32,
    parameter int unsigned          DATA_W = 8,
    parameter logic [CRC_W-1:0]     POLY   = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // Serial LFSR unrolled over one data word, least significant bit first.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int i = 0; i < int'(DATA_W); i++) begin
            fb  = acc[CRC_W-1] ^ data_in[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int unsigned NREGS = 4,
    parameter int unsigned REG_W = 16,
    localparam int unsigned SEL_W = $clog2(NREGS),
    localparam int unsigned BIT_W = $clog2(REG_W),
    localparam int unsigned IDX_W = SEL_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_en,
    output logic [REG_W-1:0] rd_data,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_bit
);
    logic [REG_W-1:0] regs [NREGS];

    for (genvar g = 0; g < int'(NREGS); g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data  = regs[wr_sel];
        look_bit = regs[look_idx[IDX_W-1:BIT_W]][look_idx[BIT_W-1:0]];
    end
endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_OCTETS = 6,
    parameter int unsigned IDX_W       = 6,
    localparam int unsigned CNT_W      = $clog2(ADDR_OCTETS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_start,
    input  logic               addr_valid,
    input  logic [OCTET_W-1:0] addr_byte,
    input  logic               hash_en,
    input  logic               rx_all,
    input  logic               rx_mcast,
    input  logic               look_bit,
    output logic [IDX_W-1:0]   hash_idx,
    output logic               dec_valid,
    output logic               dec_accept
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_OCTETS - 1);

    mhf_state_e         state_q, state_d;
    logic [CRC_W-1:0]   crc_q, crc_seed, crc_next;
    logic [CNT_W-1:0]   cnt_q;
    logic               mc_q;
    logic               begin_addr;
    logic               take_octet;

    assign begin_addr = addr_start && addr_valid;
    assign take_octet = addr_valid && !addr_start && (state_q == ST_COLLECT);
    assign crc_seed   = begin_addr ? CRC_PRESET : crc_q;

    mhf_crc_step #(
        .CRC_W (CRC_W),
        .DATA_W(OCTET_W),
        .POLY  (CRC_POLY)
    ) u_step (
        .crc_in (crc_seed),
        .data_in(addr_byte),
        .crc_out(crc_next)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (begin_addr) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (begin_addr)                         state_d = ST_COLLECT;
                else if (take_octet && cnt_q == LAST_CNT) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                state_d = begin_addr ? ST_COLLECT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address datapath: CRC accumulator, octet count, group bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
            cnt_q <= '0;
            mc_q  <= 1'b0;
        end else if (begin_addr) begin
            crc_q <= crc_next;
            cnt_q <= CNT_W'(1);
            mc_q  <= addr_byte[0];
        end else if (take_octet) begin
            crc_q <= crc_next;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign hash_idx = crc_q[CRC_W-1 -: IDX_W];

    // Outputs
    always_comb begin
        dec_valid  = 1'b0;
        dec_accept = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: begin
                dec_valid  = 1'b0;
                dec_accept = 1'b0;
            end
            ST_DECIDE: begin
                dec_valid  = 1'b1;
                dec_accept = mc_q && (rx_all || rx_mcast || (hash_en && look_bit));
            end
            default: begin
                dec_valid  = 1'b0;
                dec_accept = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int unsigned ADDR_OCTETS = 6,
    parameter int unsigned NREGS       = 4,
    parameter int unsigned REG_W       = 16,
    localparam int unsigned SEL_W      = $clog2(NREGS),
    localparam int unsigned IDX_W      = SEL_W + $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_start,
    input  logic             addr_valid,
    input  logic [7:0]       addr_byte,
    input  logic             hash_en,
    input  logic             rx_all,
    input  logic             rx_mcast,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_we,
    output logic [REG_W-1:0] reg_rdata,
    output logic             dec_valid,
    output logic             dec_accept
);
    logic [IDX_W-1:0] hash_idx;
    logic             look_bit;

    mhf_table #(
        .NREGS(NREGS),
        .REG_W(REG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .wr_en   (reg_we),
        .rd_data (reg_rdata),
        .look_idx(hash_idx),
        .look_bit(look_bit)
    );

    mhf_ctrl #(
        .ADDR_OCTETS(ADDR_OCTETS),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_start(addr_start),
        .addr_valid(addr_valid),
        .addr_byte (addr_byte),
        .hash_en   (hash_en),
        .rx_all    (rx_all),
        .rx_mcast  (rx_mcast),
        .look_bit  (look_bit),
        .hash_idx  (hash_idx),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept)
    );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_start,
    input logic             addr_valid,
    input logic [7:0]       addr_byte,
    input logic             hash_en,
    input logic             rx_all,
    input logic             rx_mcast,
    input logic [SEL_W-1:0] reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_rdata,
    input logic             dec_valid,
    input logic             dec_accept
);
    logic armed;
    logic grp_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            grp_seen <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (addr_start && addr_valid) grp_seen <= addr_byte[0];
        end
    end

    // R2: a write is visible on readback one cycle later when the select holds
    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(reg_we) && reg_sel == $past(reg_sel)) |-> reg_rdata == $past(reg_wdata));

    // R9: decision strobe never lasts two cycles
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R9: accept is only ever raised together with the strobe
    p_accept_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    // R7: individual destinations never match
    p_unicast_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_valid && !grp_seen) |-> !dec_accept);

    // R6: overrides admit every group destination
    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_valid && grp_seen && (rx_all || rx_mcast)) |-> dec_accept);

    // R8: with every mode off nothing is admitted
    p_modes_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !hash_en && !rx_all && !rx_mcast) |-> !dec_accept);
endmodule

bind mcast_hash_filter mhf_checker #(.SEL_W(SEL_W), .REG_W(REG_W)) u_mhf_checker (.*);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_start = 1'b0, addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        hash_en = 1'b0, rx_all = 1'b0, rx_mcast = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        dec_valid, dec_accept;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] tbl [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter uut (
        .clk(clk), .rst_n(rst_n),
        .addr_start(addr_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .hash_en(hash_en), .rx_all(rx_all), .rx_mcast(rx_mcast),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    function automatic logic exp_accept(input logic [47:0] a, input logic he,
                                        input logic ra, input logic rm);
        logic [5:0] ix = hidx(a);
        if (!a[0]) return 1'b0;
        if (ra || rm) return 1'b1;
        return he && tbl[ix[5:4]][ix[3:0]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        tbl[s] = d;
    endtask

    task automatic rd_check(input logic [1:0] s, input string req);
        @(negedge clk);
        reg_sel = s;
        #1 check(req, reg_rdata, tbl[s]);
    endtask

    // Sends the first n octets; gaps inserted randomly when gaps set.
    task automatic send(input logic [47:0] a, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                int g = $urandom_range(0, 2);
                for (int k = 0; k < g; k++) begin
                    @(negedge clk);
                    addr_valid = 1'b0; addr_start = 1'b0;
                    check("R9 no early strobe", dec_valid, 0);
                end
            end
            @(negedge clk);
            if (i > 0) check("R9 no early strobe", dec_valid, 0);
            addr_valid = 1'b1; addr_start = (i == 0); addr_byte = a[8*i +: 8];
        end
    endtask

    // Full address, then sample the decision cycle; optionally write during it.
    task automatic decide(input logic [47:0] a, input bit gaps, input string req,
                          input bit wr_now, input logic [1:0] ws, input logic [15:0] wd);
        logic ex;
        send(a, 6, gaps);
        @(negedge clk);
        addr_valid = 1'b0; addr_start = 1'b0;
        ex = exp_accept(a, hash_en, rx_all, rx_mcast);
        if (wr_now) begin
            reg_sel = ws; reg_wdata = wd; reg_we = 1'b1;
        end
        check({req, " R9 strobe"}, dec_valid, 1);
        check(req, dec_accept, ex);
        @(negedge clk);
        reg_we = 1'b0;
        if (wr_now) tbl[ws] = wd;
        check("R9 strobe drops", dec_valid, 0);
    endtask

    initial begin
        int unsigned seed;
        logic [47:0] a, b;
        logic [5:0]  ix;
        seed = $urandom(32'h1234_5678);
        for (int i = 0; i < 4; i++) tbl[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 strobe low in reset", dec_valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rd_check(2'(i), "R1 reset table");

        // R2 write and readback
        for (int i = 0; i < 4; i++) wr(2'(i), 16'($urandom));
        for (int i = 3; i >= 0; i--) rd_check(2'(i), "R2 readback");
        for (int i = 0; i < 4; i++) wr(2'(i), 16'h0);

        // R5/R3/R4 directed on one group address
        hash_en = 1'b1;
        a = 48'h0000_5E00_0001 | 48'h1;
        ix = hidx(a);
        decide(a, 0, "R5 bit clear drops", 0, 0, 0);
        wr(ix[5:4], 16'(1) << ix[3:0]);
        decide(a, 0, "R3 R4 indexed bit accepts", 0, 0, 0);
        wr(ix[5:4], ~(16'(1) << ix[3:0]));
        for (int i = 0; i < 4; i++) if (2'(i) != ix[5:4]) wr(2'(i), 16'hFFFF);
        decide(a, 0, "R4 all other bits set drops", 0, 0, 0);

        // R7 individual address with full table
        for (int i = 0; i < 4; i++) wr(2'(i), 16'hFFFF);
        decide(48'h1234_5678_9AB2, 0, "R7 unicast drops", 0, 0, 0);
        rx_all = 1'b1;
        decide(48'h1234_5678_9AB2, 0, "R7 unicast with override", 0, 0, 0);

        // R6 overrides with empty table
        for (int i = 0; i < 4; i++) wr(2'(i), 16'h0);
        decide(48'hABCD_EF01_2303, 0, "R6 receive-all", 0, 0, 0);
        rx_all = 1'b0; rx_mcast = 1'b1; hash_en = 1'b0;
        decide(48'h0102_0304_0507, 0, "R6 receive-multicast", 0, 0, 0);

        // R8 all modes off
        rx_mcast = 1'b0;
        for (int i = 0; i < 4; i++) wr(2'(i), 16'hFFFF);
        decide(48'h0102_0304_0507, 0, "R8 modes off drops", 0, 0, 0);

        // R10 restart after a partial address
        hash_en = 1'b1;
        for (int i = 0; i < 4; i++) wr(2'(i), 16'h0);
        a = 48'h1111_2222_3333 | 48'h1;
        b = 48'h7777_8888_9999;
        ix = hidx(b);
        wr(ix[5:4], 16'(1) << ix[3:0]);
        send(a, 3, 0);
        decide(b, 0, "R10 restart", 0, 0, 0);

        // R11 write during decision cycle
        ix = hidx(b);
        decide(b, 0, "R11 old value used", 1, ix[5:4], 16'h0);
        decide(b, 0, "R11 new value next", 0, 0, 0);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), 16'($urandom));
            hash_en  = ($urandom_range(0, 3) != 0);
            rx_all   = ($urandom_range(0, 7) == 0);
            rx_mcast = ($urandom_range(0, 7) == 0);
            a = {16'($urandom), 32'($urandom)};
            decide(a, 1, "R5 random lookup", $urandom_range(0, 9) == 0,
                   2'($urandom_range(0, 3)), 16'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule